// File: doc/BRIEF.md
# Protected Settings Store Controller

This block keeps two copies of a peripheral bridge's configuration. One is a stored default bank that survives reset. The other is a working copy that the rest of the bridge reads through `cfg_out`. Every reset reloads the working copy from the stored bank. The host can then reshape the working copy freely, for example to talk to a second attached device with different transfer settings. When it wants the current working settings to become the new defaults, it commits them.

The stored bank also holds an access mode and an eight-byte key. In the open mode every change to the stored bank is accepted. In the guarded mode a change is accepted only after the host has presented the right key since the last reset. The sealed mode refuses all further changes to the stored bank and cannot be left. Changes to the working copy are never refused. Commands arrive on a valid/ready port. Each command produces one response carrying a status code and, for reads, a data word.

Top module: `settings_store`

## Requirements
- R1: At reset the working copy is loaded from the stored bank, and `cfg_out` shows it from the first cycle after reset is released. Out of manufacture the access mode is open (`mode_out` = 0) and stored word i holds (48 + 17·i) mod 256.
- R2: Command code 1 (working write) stores `cmd_data` at `cmd_addr` in the working copy. It returns status 0 in every access mode.
- R3: Command code 0 (working read) returns the working word at `cmd_addr`. Command code 2 (stored read) returns the stored word. Both return status 0.
- R4: Code 3 (stored write), code 4 (commit), code 5 (set mode from `cmd_data[1:0]`) and code 6 (set key from `cmd_key`) each change the stored bank and return status 0 when the policy allows it. The policy allows it in open mode (0), and in guarded mode (1) while the session is unlocked.
- R5: In guarded mode without a session unlock, codes 3 to 6 return status 1 (denied) and leave the stored bank and `mode_out` unchanged.
- R6: Code 7 (unlock) compares `cmd_key` one byte per cycle. `cmd_ready` stays low for exactly 8 cycles after the accept, and the response appears 8 cycles after the accept. A matching key returns status 0 and unlocks the session.
- R7: A key that differs in any byte returns status 2 and locks the session again.
- R8: In sealed mode (2), codes 3 to 6 return status 1 even after a correct unlock, so the mode can never leave 2.
- R9: A commit copies every working word into the stored bank, and those values are the working copy after the next reset.
- R10: Every command other than unlock is accepted while `cmd_ready` is high. Its single-cycle response appears in the cycle after the accept.
- R11: A set-mode command with the unused mode code 3 returns status 1 and leaves the mode unchanged.
- R12: A command presented while reset is asserted has no effect. Reset takes priority.
- R13: Reset clears the session unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (low while a key compare runs) |
| cmd_op | input | 3 | Command code 0..7 |
| cmd_addr | input | 4 | Word index |
| cmd_data | input | 8 | Write data or new mode code |
| cmd_key | input | 64 | Key for set-key and unlock |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 denied, 2 wrong key |
| rsp_data | output | 8 | Read data (zero for non-read commands) |
| cfg_out | output | 128 | Working copy, word i at bits 8i+7:8i |
| mode_out | output | 2 | Stored access mode |

## Verification
Two events can fall in the same cycle: reset reloading the working copy, and a working write arriving on the command port. The bench holds a working write to word 0 valid for the whole reset pulse. It then checks that `cfg_out` equals the stored bank, not the written value. The other pairing is a policy decision made in the cycle that follows a session change. The bench puts a stored write directly after an unlock response, and directly after a reset, so that a stale unlock flag would show up as the wrong status.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic [2:0] {
      OP_RD_WORK  = 3'd0,
      OP_WR_WORK  = 3'd1,
      OP_RD_STORE = 3'd2,
      OP_WR_STORE = 3'd3,
      OP_COMMIT   = 3'd4,
      OP_SET_MODE = 3'd5,
      OP_SET_KEY  = 3'd6,
      OP_UNLOCK   = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      ST_OK     = 2'd0,
      ST_DENIED = 2'd1,
      ST_BADKEY = 2'd2
   } status_e;

   localparam logic [1:0] MODE_OPEN    = 2'd0;
   localparam logic [1:0] MODE_GUARDED = 2'd1;
   localparam logic [1:0] MODE_SEALED  = 2'd2;
endpackage

// File: rtl/ssc_nv_bank.sv
module ssc_nv_bank #(
   parameter int unsigned NUM_WORDS = 16,
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned KEY_BYTES = 8,
   parameter int unsigned CFG_SEED  = 48,
   parameter int unsigned CFG_STEP  = 17,
   parameter logic [KEY_BYTES*8-1:0] FACTORY_KEY = {KEY_BYTES{8'hA5}}
) (
   input  logic                        clk,
   input  logic                        word_we,
   input  logic [$clog2(NUM_WORDS)-1:0] word_addr,
   input  logic [WORD_W-1:0]           word_data,
   input  logic                        commit_we,
   input  logic [NUM_WORDS*WORD_W-1:0] commit_data,
   input  logic                        key_we,
   input  logic [KEY_BYTES*8-1:0]      key_data,
   input  logic                        mode_we,
   input  logic [1:0]                  mode_data,
   output logic [NUM_WORDS*WORD_W-1:0] cfg_out,
   output logic [KEY_BYTES*8-1:0]      key_out,
   output logic [1:0]                  mode_out
);
   localparam int unsigned AW = $clog2(NUM_WORDS);

   // Non-volatile cells: no reset, factory contents as power-on values.
   logic [KEY_BYTES*8-1:0] key_q  = FACTORY_KEY;
   logic [1:0]             mode_q = ssc_pkg::MODE_OPEN;

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      logic [WORD_W-1:0] word_q = WORD_W'(CFG_SEED + i * CFG_STEP);
      always_ff @(posedge clk) begin
         if (commit_we)
            word_q <= commit_data[i*WORD_W +: WORD_W];
         else if (word_we && word_addr == AW'(i))
            word_q <= word_data;
      end
      assign cfg_out[i*WORD_W +: WORD_W] = word_q;
   end

   always_ff @(posedge clk) begin
      if (key_we)  key_q  <= key_data;
      if (mode_we) mode_q <= mode_data;
   end

   assign key_out  = key_q;
   assign mode_out = mode_q;
endmodule

// File: rtl/ssc_key_check.sv
module ssc_key_check #(
   parameter int unsigned KEY_BYTES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [KEY_BYTES*8-1:0] key_in,
   input  logic [KEY_BYTES*8-1:0] key_ref,
   output logic                   busy,
   output logic                   last,
   output logic                   match
);
   localparam int unsigned KW = KEY_BYTES * 8;
   localparam int unsigned IW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

   logic [KW-1:0] key_q;
   logic [IW-1:0] idx_q;
   logic          busy_q, ok_q, byte_eq;

   assign byte_eq = key_q[idx_q*8 +: 8] == key_ref[idx_q*8 +: 8];
   assign busy    = busy_q;
   assign last    = busy_q && (idx_q == IW'(KEY_BYTES - 1));
   assign match   = ok_q && byte_eq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q  <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
         ok_q   <= 1'b0;
      end else if (start) begin
         key_q  <= key_in;
         idx_q  <= '0;
         busy_q <= 1'b1;
         ok_q   <= 1'b1;
      end else if (busy_q) begin
         ok_q <= ok_q && byte_eq;
         if (last) busy_q <= 1'b0;
         else      idx_q  <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/ssc_policy.sv
module ssc_policy
   import ssc_pkg::*;
(
   input  op_e        op,
   input  logic [1:0] mode,
   input  logic       unlocked,
   input  logic [1:0] new_mode,
   output logic       alters_store,
   output logic       grant
);
   logic base_ok;

   always_comb begin
      alters_store = (op == OP_WR_STORE) || (op == OP_COMMIT) ||
                     (op == OP_SET_MODE) || (op == OP_SET_KEY);
      base_ok = (mode == MODE_OPEN) || (mode == MODE_GUARDED && unlocked);
      grant   = base_ok && ((op != OP_SET_MODE) || (new_mode != 2'd3));
   end
endmodule

// File: rtl/settings_store.sv
module settings_store
   import ssc_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 16,
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned KEY_BYTES = 8,
   parameter int unsigned CFG_SEED  = 48,
   parameter int unsigned CFG_STEP  = 17,
   parameter logic [KEY_BYTES*8-1:0] FACTORY_KEY = {KEY_BYTES{8'hA5}}
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   output logic                        cmd_ready,
   input  logic [2:0]                  cmd_op,
   input  logic [$clog2(NUM_WORDS)-1:0] cmd_addr,
   input  logic [WORD_W-1:0]           cmd_data,
   input  logic [KEY_BYTES*8-1:0]      cmd_key,
   output logic                        rsp_valid,
   output logic [1:0]                  rsp_status,
   output logic [WORD_W-1:0]           rsp_data,
   output logic [NUM_WORDS*WORD_W-1:0] cfg_out,
   output logic [1:0]                  mode_out
);
   localparam int unsigned AW = $clog2(NUM_WORDS);
   localparam int unsigned CW = NUM_WORDS * WORD_W;
   localparam int unsigned KW = KEY_BYTES * 8;

   if (NUM_WORDS < 2 || (1 << AW) != NUM_WORDS) begin : g_bad_words
      $error("NUM_WORDS must be a power of two of at least 2");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must hold a two-bit mode code");
   end
   if (KEY_BYTES < 1) begin : g_bad_key
      $error("KEY_BYTES must be at least 1");
   end

   op_e           op;
   logic          accept, grant, alters_store;
   logic          key_busy, key_last, key_match;
   logic          unlocked_q;
   logic [CW-1:0] ram_q, nv_cfg;
   logic [KW-1:0] nv_key;
   logic [1:0]    nv_mode;
   logic          rsp_valid_q;
   status_e       rsp_status_q;
   logic [WORD_W-1:0] rsp_data_q;

   assign op        = op_e'(cmd_op);
   assign cmd_ready = !key_busy;
   assign accept    = cmd_valid && !key_busy;

   ssc_policy u_policy (
      .op           (op),
      .mode         (nv_mode),
      .unlocked     (unlocked_q),
      .new_mode     (cmd_data[1:0]),
      .alters_store (alters_store),
      .grant        (grant)
   );

   ssc_nv_bank #(
      .NUM_WORDS   (NUM_WORDS),
      .WORD_W      (WORD_W),
      .KEY_BYTES   (KEY_BYTES),
      .CFG_SEED    (CFG_SEED),
      .CFG_STEP    (CFG_STEP),
      .FACTORY_KEY (FACTORY_KEY)
   ) u_bank (
      .clk         (clk),
      .word_we     (rst_n && accept && op == OP_WR_STORE && grant),
      .word_addr   (cmd_addr),
      .word_data   (cmd_data),
      .commit_we   (rst_n && accept && op == OP_COMMIT && grant),
      .commit_data (ram_q),
      .key_we      (rst_n && accept && op == OP_SET_KEY && grant),
      .key_data    (cmd_key),
      .mode_we     (rst_n && accept && op == OP_SET_MODE && grant),
      .mode_data   (cmd_data[1:0]),
      .cfg_out     (nv_cfg),
      .key_out     (nv_key),
      .mode_out    (nv_mode)
   );

   ssc_key_check #(.KEY_BYTES(KEY_BYTES)) u_keychk (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept && op == OP_UNLOCK),
      .key_in  (cmd_key),
      .key_ref (nv_key),
      .busy    (key_busy),
      .last    (key_last),
      .match   (key_match)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_q        <= nv_cfg;
         unlocked_q   <= 1'b0;
         rsp_valid_q  <= 1'b0;
         rsp_status_q <= ST_OK;
         rsp_data_q   <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
         if (key_last) begin
            rsp_valid_q  <= 1'b1;
            rsp_status_q <= key_match ? ST_OK : ST_BADKEY;
            unlocked_q   <= key_match;
         end else if (accept && op != OP_UNLOCK) begin
            rsp_valid_q  <= 1'b1;
            rsp_status_q <= ST_OK;
            unique case (op)
               OP_RD_WORK:  rsp_data_q <= ram_q[cmd_addr*WORD_W +: WORD_W];
               OP_RD_STORE: rsp_data_q <= nv_cfg[cmd_addr*WORD_W +: WORD_W];
               OP_WR_WORK:  ram_q[cmd_addr*WORD_W +: WORD_W] <= cmd_data;
               default:     rsp_status_q <= (alters_store && !grant) ? ST_DENIED : ST_OK;
            endcase
         end
      end
   end

   assign rsp_valid  = rsp_valid_q;
   assign rsp_status = rsp_status_q;
   assign rsp_data   = rsp_data_q;
   assign cfg_out    = ram_q;
   assign mode_out   = nv_mode;
endmodule

// File: rtl/settings_store_chk.sv
module settings_store_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic [2:0] cmd_op,
   input logic       rsp_valid,
   input logic [1:0] rsp_status,
   input logic [1:0] mode_out,
   input logic       unlocked,
   input logic       key_busy
);
   logic acc;
   assign acc = cmd_valid && cmd_ready;

   a_r10_resp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op != 3'd7) |=> rsp_valid);

   a_r6_busy_blocks_cmds: assert property (@(posedge clk) disable iff (!rst_n)
      key_busy |-> !cmd_ready);

   a_r8_sealed_is_final: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out == 2'd2) |=> (mode_out == 2'd2));

   a_r5_guarded_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mode_out == 2'd1 && !unlocked) |=> $stable(mode_out));

   a_r2_work_write_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd1) |=> (rsp_status == 2'd0));

   a_r7_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_status != 2'd3));

   a_r13_reset_locks_session: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !unlocked);
endmodule

bind settings_store settings_store_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_op     (cmd_op),
   .rsp_valid  (rsp_valid),
   .rsp_status (rsp_status),
   .mode_out   (mode_out),
   .unlocked   (unlocked_q),
   .key_busy   (key_busy)
);

// File: tb/test_settings_store.sv
module test_settings_store;
   localparam int N = 16;
   localparam int P = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic [2:0]   cmd_op = '0;
   logic [3:0]   cmd_addr = '0;
   logic [7:0]   cmd_data = '0;
   logic [63:0]  cmd_key = '0;
   logic         rsp_valid;
   logic [1:0]   rsp_status;
   logic [7:0]   rsp_data;
   logic [127:0] cfg_out;
   logic [1:0]   mode_out;

   int vectors = 0, miscompares = 0, cyc = 0;
   bit done = 0;

   logic [7:0]  m_nv [N];
   logic [7:0]  m_ram [N];
   logic [63:0] m_key;
   logic [1:0]  m_mode;
   bit          m_unl;

   settings_store i_settings_store (.*);

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         vectors++; miscompares++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] work_flat();
      logic [127:0] f;
      for (int i = 0; i < N; i++) f[i*8 +: 8] = m_ram[i];
      return f;
   endfunction

   function automatic bit grant_ok();
      return (m_mode == 2'd0) || (m_mode == 2'd1 && m_unl);
   endfunction

   function automatic logic [1:0] exp_status(input logic [2:0] op, input logic [7:0] d, input logic [63:0] k);
      case (op)
         3'd0, 3'd1, 3'd2: return 2'd0;
         3'd7:             return (k == m_key) ? 2'd0 : 2'd2;
         3'd5:             return (grant_ok() && d[1:0] != 2'd3) ? 2'd0 : 2'd1;
         default:          return grant_ok() ? 2'd0 : 2'd1;
      endcase
   endfunction

   task automatic do_cmd(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d,
                         input logic [63:0] k, input string req);
      logic [1:0] es;
      logic [7:0] ed;
      es = exp_status(op, d, k);
      ed = (op == 3'd0) ? m_ram[a] : (op == 3'd2) ? m_nv[a] : 8'h00;
      @(negedge clk);
      chk(cmd_ready == 1'b1, {req, " R10 ready"}, cmd_ready, 1);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_key = k;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (op == 3'd7) begin
         for (int i = 0; i < P; i++) begin
            chk(!cmd_ready && !rsp_valid, "R6 compare window", {cmd_ready, rsp_valid}, 0);
            @(negedge clk);
         end
      end
      chk(rsp_valid == 1'b1, {req, " R10 rsp_valid"}, rsp_valid, 1);
      chk(rsp_status == es, {req, " status"}, rsp_status, es);
      if (op == 3'd0 || op == 3'd2) chk(rsp_data == ed, {req, " R3 data"}, rsp_data, ed);
      if (es == 2'd0 || op == 3'd7) begin
         case (op)
            3'd1: m_ram[a] = d;
            3'd3: m_nv[a] = d;
            3'd4: for (int i = 0; i < N; i++) m_nv[i] = m_ram[i];
            3'd5: m_mode = d[1:0];
            3'd6: m_key = k;
            3'd7: m_unl = (k == m_key);
            default: ;
         endcase
      end
      @(negedge clk);
      chk(cfg_out == work_flat(), {req, " R2 cfg_out"}, cfg_out, work_flat());
      chk(mode_out == m_mode, {req, " mode_out"}, mode_out, m_mode);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 4'd0; cmd_data = ~m_nv[0];
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      rst_n = 1'b1;
      for (int i = 0; i < N; i++) m_ram[i] = m_nv[i];
      m_unl = 1'b0;
      @(negedge clk);
      chk(cfg_out == work_flat(), "R1 R12 reload after reset", cfg_out, work_flat());
   endtask

   initial begin
      logic [63:0] k1;
      void'($urandom(32'd1357));
      for (int i = 0; i < N; i++) begin m_nv[i] = 8'(48 + 17 * i); m_ram[i] = m_nv[i]; end
      m_key = {8{8'hA5}}; m_mode = 2'd0; m_unl = 1'b0;
      k1 = 64'h1122_3344_5566_7788;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cfg_out == work_flat(), "R1 factory working copy", cfg_out, work_flat());
      chk(mode_out == 2'd0, "R1 factory mode", mode_out, 0);
      chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
      do_cmd(3'd2, 4'd15, 8'h00, 64'h0, "R3 stored read");

      // open mode: random mix of reads, writes and commits
      for (int it = 0; it < 200; it++) begin
         do_cmd(3'($urandom % 5), 4'($urandom), 8'($urandom), 64'h0, "R4 open mix");
         if (it % 50 == 49) do_reset();
      end
      do_reset();

      // guarded mode
      do_cmd(3'd6, 4'd0, 8'h00, k1, "R4 set key");
      do_cmd(3'd5, 4'd0, 8'd1, 64'h0, "R4 to guarded");
      do_cmd(3'd3, 4'd2, 8'h5C, 64'h0, "R5 stored write denied");
      do_cmd(3'd2, 4'd2, 8'h00, 64'h0, "R5 stored unchanged");
      do_cmd(3'd5, 4'd0, 8'd0, 64'h0, "R5 mode change denied");
      do_cmd(3'd1, 4'd2, 8'hC3, 64'h0, "R2 work write guarded");
      do_cmd(3'd7, 4'd0, 8'h00, k1 ^ 64'hFF, "R7 wrong low byte");
      do_cmd(3'd7, 4'd0, 8'h00, k1, "R6 correct key");
      do_cmd(3'd3, 4'd2, 8'h5C, 64'h0, "R4 stored write after unlock");
      do_cmd(3'd7, 4'd0, 8'h00, k1 ^ (64'hFF << 56), "R7 wrong top byte");
      do_cmd(3'd4, 4'd0, 8'h00, 64'h0, "R7 commit denied after bad key");
      do_cmd(3'd7, 4'd0, 8'h00, k1, "R6 unlock again");
      do_cmd(3'd1, 4'd9, 8'h9E, 64'h0, "R2 work write");
      do_cmd(3'd4, 4'd0, 8'h00, 64'h0, "R9 commit");
      do_reset();
      chk(cfg_out[9*8 +: 8] == 8'h9E, "R9 committed word after reset", cfg_out[9*8 +: 8], 8'h9E);
      do_cmd(3'd3, 4'd1, 8'h11, 64'h0, "R13 write denied after reset");
      do_cmd(3'd7, 4'd0, 8'h00, k1, "R6 unlock");
      do_cmd(3'd5, 4'd0, 8'd3, 64'h0, "R11 unused mode code");
      do_cmd(3'd5, 4'd0, 8'd2, 64'h0, "R4 to sealed");

      // sealed mode
      do_cmd(3'd7, 4'd0, 8'h00, k1, "R8 unlock in sealed");
      do_cmd(3'd5, 4'd0, 8'd0, 64'h0, "R8 leave sealed denied");
      do_cmd(3'd6, 4'd0, 8'h00, 64'h0, "R8 set key denied");
      do_cmd(3'd3, 4'd4, 8'h77, 64'h0, "R8 stored write denied");
      do_cmd(3'd1, 4'd4, 8'h77, 64'h0, "R2 work write sealed");
      for (int it = 0; it < 60; it++) begin
         logic [2:0] op;
         op = 3'($urandom);
         do_cmd(op, 4'($urandom), 8'($urandom), ($urandom % 2) ? m_key : 64'($urandom), "R8 sealed mix");
      end
      do_reset();
      chk(mode_out == 2'd2, "R8 sealed survives reset", mode_out, 2);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule